// File: doc/BRIEF.md
# Auto-Stepping Address Pointer File

This block holds a small set of address pointers and produces an effective
address from one of them on each request. A requester names a pointer,
picks an addressing mode and supplies a step. The mode decides both the
address that is sent out and how the chosen pointer moves. In plain
indirect mode the pointer is used as it stands. In post-increment mode the
current value is used first and the pointer then moves up by the step. In
pre-decrement mode the pointer moves down by the step first, and the new
value becomes the address.

The step is meant to be the size of one element. Repeated post-increment
requests therefore walk through consecutive array elements. Pairing
pre-decrement (push) with post-increment (pop) on one pointer makes that
pointer the address engine of a last-in-first-out stack that grows
downward.

A separate load port writes a pointer directly, so software can set a
pointer before using it. The memory array and the operand arithmetic sit
outside this block.

Top module: `addr_ptr_unit`

## Requirements
- R1: After reset every pointer reads 0, `ea_vld_o` is 0, and `ea_o` and `upd_o` are 0.
- R2: A request with `mode_i` 2'b00 (indirect) or 2'b11 (treated as indirect) returns the selected pointer on `ea_o` and on `upd_o`, and leaves the pointer unchanged.
- R3: A request with `mode_i` 2'b01 (post-increment) returns the old pointer value on `ea_o`. The pointer becomes old + `step_i`, and that new value appears on `upd_o`.
- R4: A request with `mode_i` 2'b10 (pre-decrement) makes the pointer old - `step_i`. That reduced value appears on both `ea_o` and `upd_o`.
- R5: Pointer arithmetic wraps modulo 2^AW (2^16 by default), in both directions.
- R6: An accepted request sampled at a rising edge drives `ea_vld_o` high, with `ea_o` and `upd_o` valid, from that edge until the next one. The pointer update takes effect at the same edge.
- R7: With `ld_i` high, the pointer at `ld_sel_i` takes `ld_val_i` at the edge, and a request in the next cycle sees that value.
- R8: When a load and a request target the same pointer in the same cycle, the load wins. The request is dropped: `ea_vld_o` stays low, and `ea_o`/`upd_o` hold their previous values.
- R9: A load to one pointer and a request to a different pointer in the same cycle are both carried out.
- R10: Pre-decrement pushes followed by post-increment pops, with the same step on one pointer, return the push addresses in reverse order and restore the pointer's starting value.
- R11: In a cycle without an accepted request, `ea_vld_o` is low and `ea_o`/`upd_o` keep their last values.
- R12: A request changes only the selected pointer; all other pointers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 1 | Request strobe |
| sel_i | input | SEL_W (3) | Pointer chosen for the request |
| mode_i | input | 2 | Addressing mode: 00 indirect, 01 post-increment, 10 pre-decrement, 11 indirect |
| step_i | input | AW (16) | Step, one element size |
| ld_i | input | 1 | Load strobe |
| ld_sel_i | input | SEL_W (3) | Pointer to load |
| ld_val_i | input | AW (16) | Value to load |
| ea_o | output | AW (16) | Effective address of the last accepted request |
| upd_o | output | AW (16) | Pointer value after the last accepted request |
| ea_vld_o | output | 1 | High for one cycle per accepted request |

## Verification
The bench targets the ordering difference between the modes. A design that swapped use and update would return the stepped value in post-increment mode, or the stale value in pre-decrement mode, and the stack test would then pop addresses that are off by one step.

It drives steps across zero and across the top of the address range. Logic that saturated instead of wrapping, or that lost the carry, would return the wrong addresses there.

It issues a load and a request to the same pointer in the same cycle. A design that let the request win, or merged the two, would raise the valid flag or leave a stepped value behind instead of the loaded one. It also issues a load and a request to different pointers in the same cycle, so a design that stalled the request would be caught.

A random mix of requests with later indirect read-backs checks that only the selected pointer moves.

// File: rtl/aptr_pkg.sv
package aptr_pkg;
  typedef enum logic [1:0] {
    AM_INDIRECT = 2'b00,
    AM_POST_INC = 2'b01,
    AM_PRE_DEC  = 2'b10,
    AM_RSVD     = 2'b11
  } amode_e;
endpackage

// File: rtl/aptr_rst_sync.sv
module aptr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/aptr_regfile.sv
module aptr_regfile #(
  parameter int NUM_PTR = 8,
  parameter int AW      = 16,
  localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [AW-1:0]    rd_val,
  input  logic             ld_en,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [AW-1:0]    ld_val,
  input  logic             upd_en,
  input  logic [SEL_W-1:0] upd_sel,
  input  logic [AW-1:0]    upd_val
);
  logic [NUM_PTR-1:0][AW-1:0] ptr_all;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic          we;
    logic [AW-1:0] d;
    logic [AW-1:0] q;

    // the load port has priority over the stepping update
    always_comb begin
      we = 1'b0;
      d  = q;
      if (ld_en && (ld_sel == SEL_W'(g))) begin
        we = 1'b1;
        d  = ld_val;
      end else if (upd_en && (upd_sel == SEL_W'(g))) begin
        we = 1'b1;
        d  = upd_val;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
    end

    assign ptr_all[g] = q;
  end

  assign rd_val = ptr_all[rd_sel];
endmodule

// File: rtl/aptr_calc.sv
module aptr_calc
  import aptr_pkg::*;
#(
  parameter int AW     = 16,
  parameter int SEL_W  = 3
) (
  input  logic             req,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       mode,
  input  logic [AW-1:0]    step,
  input  logic [AW-1:0]    cur,
  input  logic             ld_en,
  input  logic [SEL_W-1:0] ld_sel,
  output logic             accept,
  output logic             wr,
  output logic [AW-1:0]    ea,
  output logic [AW-1:0]    nxt
);
  amode_e        m;
  logic [AW-1:0] inc_v;
  logic [AW-1:0] dec_v;
  logic          collide;

  assign m       = amode_e'(mode);
  assign inc_v   = cur + step;
  assign dec_v   = cur - step;
  assign collide = ld_en && (ld_sel == sel);

  always_comb begin
    accept = req && !collide;
    ea     = cur;
    nxt    = cur;
    wr     = 1'b0;
    unique case (m)
      AM_POST_INC: begin
        nxt = inc_v;
        wr  = accept;
      end
      AM_PRE_DEC: begin
        ea  = dec_v;
        nxt = dec_v;
        wr  = accept;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/aptr_outreg.sv
module aptr_outreg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] ea_d,
  input  logic [AW-1:0] upd_d,
  output logic [AW-1:0] ea_q,
  output logic [AW-1:0] upd_q,
  output logic          vld_q
);
  logic [AW-1:0] ea_n;
  logic [AW-1:0] upd_n;

  always_comb begin
    ea_n  = ea_q;
    upd_n = upd_q;
    if (accept) begin
      ea_n  = ea_d;
      upd_n = upd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q  <= '0;
      upd_q <= '0;
      vld_q <= 1'b0;
    end else begin
      ea_q  <= ea_n;
      upd_q <= upd_n;
      vld_q <= accept;
    end
  end
endmodule

// File: rtl/addr_ptr_unit.sv
module addr_ptr_unit #(
  parameter int NUM_PTR = 8,
  parameter int AW      = 16,
  localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       mode_i,
  input  logic [AW-1:0]    step_i,
  input  logic             ld_i,
  input  logic [SEL_W-1:0] ld_sel_i,
  input  logic [AW-1:0]    ld_val_i,
  output logic [AW-1:0]    ea_o,
  output logic [AW-1:0]    upd_o,
  output logic             ea_vld_o
);
  logic          rst_q_n;
  logic [AW-1:0] cur;
  logic          accept;
  logic          wr;
  logic [AW-1:0] ea_d;
  logic [AW-1:0] nxt;

  aptr_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  aptr_regfile #(.NUM_PTR(NUM_PTR), .AW(AW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .rd_sel  (sel_i),
    .rd_val  (cur),
    .ld_en   (ld_i),
    .ld_sel  (ld_sel_i),
    .ld_val  (ld_val_i),
    .upd_en  (wr),
    .upd_sel (sel_i),
    .upd_val (nxt)
  );

  aptr_calc #(.AW(AW), .SEL_W(SEL_W)) u_calc (
    .req    (req_i),
    .sel    (sel_i),
    .mode   (mode_i),
    .step   (step_i),
    .cur    (cur),
    .ld_en  (ld_i),
    .ld_sel (ld_sel_i),
    .accept (accept),
    .wr     (wr),
    .ea     (ea_d),
    .nxt    (nxt)
  );

  aptr_outreg #(.AW(AW)) u_out (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .accept (accept),
    .ea_d   (ea_d),
    .upd_d  (nxt),
    .ea_q   (ea_o),
    .upd_q  (upd_o),
    .vld_q  (ea_vld_o)
  );
endmodule

// File: rtl/aptr_chk.sv
module aptr_chk #(
  parameter int NUM_PTR = 8,
  parameter int AW      = 16,
  localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic [SEL_W-1:0] sel_i,
  input logic [1:0]       mode_i,
  input logic [AW-1:0]    step_i,
  input logic             ld_i,
  input logic [SEL_W-1:0] ld_sel_i,
  input logic [AW-1:0]    ea_o,
  input logic [AW-1:0]    upd_o,
  input logic             ea_vld_o
);
  logic acc;
  assign acc = req_i && !(ld_i && (ld_sel_i == sel_i));

  // R6
  vld_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ea_vld_o);

  // R8
  collide_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && ld_i && (ld_sel_i == sel_i)) |=> !ea_vld_o);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> (!ea_vld_o && $stable(ea_o) && $stable(upd_o)));

  // R2
  indirect_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (mode_i == 2'b00 || mode_i == 2'b11)) |=> (upd_o == ea_o));

  // R3
  postinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode_i == 2'b01) |=> (upd_o == AW'(ea_o + $past(step_i))));

  // R4
  predec_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode_i == 2'b10) |=> (upd_o == ea_o));
endmodule

bind addr_ptr_unit aptr_chk #(.NUM_PTR(NUM_PTR), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .req_i    (req_i),
  .sel_i    (sel_i),
  .mode_i   (mode_i),
  .step_i   (step_i),
  .ld_i     (ld_i),
  .ld_sel_i (ld_sel_i),
  .ea_o     (ea_o),
  .upd_o    (upd_o),
  .ea_vld_o (ea_vld_o)
);

// File: tb/addr_ptr_unit_tb.sv
`timescale 1ns/1ps
module addr_ptr_unit_tb;
  localparam int NP = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_i;
  logic [2:0]    sel_i;
  logic [1:0]    mode_i;
  logic [AW-1:0] step_i;
  logic          ld_i;
  logic [2:0]    ld_sel_i;
  logic [AW-1:0] ld_val_i;
  logic [AW-1:0] ea_o;
  logic [AW-1:0] upd_o;
  logic          ea_vld_o;

  always #4 clk = ~clk;

  addr_ptr_unit #(.NUM_PTR(NP), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .sel_i(sel_i), .mode_i(mode_i),
    .step_i(step_i), .ld_i(ld_i), .ld_sel_i(ld_sel_i), .ld_val_i(ld_val_i),
    .ea_o(ea_o), .upd_o(upd_o), .ea_vld_o(ea_vld_o)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  logic [AW-1:0] model [NP];
  logic [AW-1:0] last_ea;
  logic [AW-1:0] last_upd;

  function automatic logic [AW-1:0] exp_ea(logic [AW-1:0] c, logic [1:0] m, logic [AW-1:0] s);
    return (m == 2'b10) ? AW'(c - s) : c;
  endfunction

  function automatic logic [AW-1:0] exp_nxt(logic [AW-1:0] c, logic [1:0] m, logic [AW-1:0] s);
    if (m == 2'b01) return AW'(c + s);
    if (m == 2'b10) return AW'(c - s);
    return c;
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    if (m == 2'b01) return "R3";
    if (m == 2'b10) return "R4";
    return "R2";
  endfunction

  task automatic chk(bit ok, string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic idle();
    req_i = 0; sel_i = 0; mode_i = 0; step_i = 0;
    ld_i = 0; ld_sel_i = 0; ld_val_i = 0;
  endtask

  // one cycle of stimulus, checked after the edge that samples it
  task automatic op(bit rq, int s, logic [1:0] m, logic [AW-1:0] st,
                    bit l, int ls, logic [AW-1:0] lv, string tag);
    bit acc;
    bit coll;
    logic [AW-1:0] e;
    logic [AW-1:0] n;
    coll = rq && l && (ls == s);
    acc  = rq && !coll;
    e    = exp_ea(model[s], m, st);
    n    = exp_nxt(model[s], m, st);
    req_i = rq; sel_i = 3'(s); mode_i = m; step_i = st;
    ld_i = l; ld_sel_i = 3'(ls); ld_val_i = lv;
    @(posedge clk);
    @(negedge clk);
    idle();
    if (acc) model[s] = n;
    if (l) model[ls] = lv;
    if (acc) begin
      chk(ea_vld_o === 1'b1, "R6", {15'd0, ea_vld_o}, 16'd1);
      chk(ea_o === e, tag.len() ? tag : mode_tag(m), ea_o, e);
      chk(upd_o === n, tag.len() ? tag : mode_tag(m), upd_o, n);
      last_ea  = e;
      last_upd = n;
    end else begin
      chk(ea_vld_o === 1'b0, coll ? "R8" : "R11", {15'd0, ea_vld_o}, 16'd0);
      chk(ea_o === last_ea, coll ? "R8" : "R11", ea_o, last_ea);
      chk(upd_o === last_upd, coll ? "R8" : "R11", upd_o, last_upd);
    end
  endtask

  task automatic read_ptr(int s, string tag);
    op(1, s, 2'b00, 16'd0, 0, 0, 16'd0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    logic [AW-1:0] pushed [3];
    void'($urandom(32'd20250));
    for (int i = 0; i < NP; i++) model[i] = '0;
    last_ea = '0; last_upd = '0;
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs in reset state
    chk(ea_vld_o === 1'b0, "R1", {15'd0, ea_vld_o}, 16'd0);
    chk(ea_o === 16'd0, "R1", ea_o, 16'd0);
    chk(upd_o === 16'd0, "R1", upd_o, 16'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NP; i++) read_ptr(i, "R1");

    // R7: load then read
    op(0, 0, 2'b00, 0, 1, 2, 16'h1234, "");
    read_ptr(2, "R7");

    // R5: wrap upward and downward
    op(0, 0, 2'b00, 0, 1, 1, 16'hFFFE, "");
    op(1, 1, 2'b01, 16'd5, 0, 0, 0, "R5");
    read_ptr(1, "R5");
    op(1, 3, 2'b10, 16'd2, 0, 0, 0, "R5");
    read_ptr(3, "R5");

    // R8: load and request on the same pointer
    op(1, 2, 2'b01, 16'd4, 1, 2, 16'h0BEE, "R8");
    read_ptr(2, "R8");

    // R9: load and request on different pointers
    op(1, 2, 2'b10, 16'd6, 1, 4, 16'h4444, "R9");
    read_ptr(4, "R9");
    read_ptr(2, "R9");

    // R12: stepping one pointer leaves its neighbours alone
    op(1, 5, 2'b01, 16'h0100, 0, 0, 0, "R12");
    read_ptr(4, "R12");
    read_ptr(6, "R12");

    // R2: reserved mode behaves as indirect
    op(1, 5, 2'b11, 16'h0077, 0, 0, 0, "R2");

    // R10: three pushes, three pops on pointer 7
    op(0, 0, 2'b00, 0, 1, 7, 16'h1000, "");
    for (int k = 0; k < 3; k++) begin
      op(1, 7, 2'b10, 16'd2, 0, 0, 0, "R10");
      pushed[k] = last_ea;
    end
    for (int k = 2; k >= 0; k--) begin
      op(1, 7, 2'b01, 16'd2, 0, 0, 0, "R10");
      chk(last_ea === pushed[k] && ea_o === pushed[k], "R10", ea_o, pushed[k]);
    end
    read_ptr(7, "R10");
    chk(ea_o === 16'h1000, "R10", ea_o, 16'h1000);

    // random mix, R11 idle cycles included
    for (int n = 0; n < 400; n++) begin
      bit rq;
      bit l;
      logic [AW-1:0] st;
      rq = ($urandom % 4) != 0;
      l  = ($urandom % 4) == 0;
      st = ($urandom % 3 == 0) ? 16'($urandom) : 16'($urandom % 8);
      op(rq, int'($urandom % NP), 2'($urandom), st,
         l, int'($urandom % NP), 16'($urandom), "");
    end
    for (int i = 0; i < NP; i++) read_ptr(i, "R12");

    done = 1'b1;
    summary();
  end
endmodule